// File: doc/BRIEF.md
# VCOM Polarity Maintenance Sequencer

This block keeps a memory-in-pixel panel free of DC bias by inverting its common-electrode polarity once per second, and it runs the power-up and power-down sequence around that. Three ways of producing the inversion can be chosen. In serial mode the block flips a polarity bit and then asks the link serializer to send a short maintain command that carries the bit. In pulse mode it drives a square wave on a dedicated pin. In external mode something outside the chip provides the inversion, so the block produces nothing.

The block also decides which command owns the serial link. Three sources compete for it: the clear commands of the power sequence, the periodic maintain commands, and frame updates requested by the display pipeline. For every grant the block presents a command kind and a one-byte header. The header always carries the current polarity bit. The serializer reports completion with a one-cycle done pulse, and only then can the next command be granted. The bit shifting itself belongs to the serializer.

Top module: `vcom_seq`

## Requirements
- R1: After reset, disp_en, extcom and link_start are 0, and the polarity bit is 0. The first maintain after a serial-mode enable therefore carries a polarity of 1.
- R2: mode_sel is captured when an enable sequence starts, with the encoding 0 = serial, 2 = pulse, 1 or 3 = external. Changing mode_sel while the panel is on has no effect.
- R3: In serial mode the polarity bit inverts every TICK_CYCLES cycles, counted from the cycle generation starts. Each inversion is followed by a maintain command (link_kind 1) whose header is 8'h00 with the polarity in bit 1.
- R4: In pulse mode, extcom starts one cycle after generation starts. Each period lasts TICK_CYCLES cycles, and extcom is high for the first HIGH_CYCLES of them. extcom is low whenever generation is stopped.
- R5: In external mode no maintain command is ever issued, and extcom stays low.
- R6: link_start is a one-cycle pulse. It never rises while a command is outstanding, meaning after the previous start and before the link_done that ends it.
- R7: On enable, a clear command is issued (link_kind 3, header 8'h04 with the polarity in bit 1). disp_en rises in the cycle after that clear's link_done is sampled, and generation starts one cycle later.
- R8: On disable, a clear command is issued. disp_en falls in the cycle after its link_done is sampled, and generation stops one cycle later.
- R9: An update (link_kind 2, header 8'h01 with the polarity in bit 1) is granted only while the panel is fully on. While the panel is off, upd_req has no effect.
- R10: Grant priority is clear, then maintain, then update. A maintain that falls due during an update is started two cycles after that update's link_done.
- R11: A link_done pulse that arrives while no command is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Level: 1 requests the panel on, 0 requests it off |
| mode_sel | input | 2 | Polarity generation mode, captured when an enable starts |
| upd_req | input | 1 | Frame update request, held until its grant is seen |
| link_done | input | 1 | Serializer finished the outstanding command |
| link_start | output | 1 | One-cycle grant of the link to a command |
| link_kind | output | 2 | Granted command: 1 maintain, 2 update, 3 clear |
| link_hdr | output | 8 | Header byte for the granted command |
| disp_en | output | 1 | Panel display-enable pin |
| extcom | output | 1 | Polarity pulse output for pulse mode |

## Verification
Serial mode is run across several periods with short link latencies, which shows that the polarity alternates in the maintain headers at the right spacing. An update with a long latency is then placed just before a tick, so that the maintain falling due is deferred and its start can be checked against the update's done. Pulse mode is measured for high time and period, and both external encodings are run to show silence on the link and on extcom. Update requests while off, a mode change while on, and a stray done pulse show which inputs are ignored. A cycle-accurate reference model compares every output on every cycle.

// File: rtl/vcom_seq_pkg.sv
package vcom_seq_pkg;

  typedef enum logic [1:0] {
    VM_SERIAL   = 2'd0,
    VM_EXTERNAL = 2'd1,
    VM_PULSE    = 2'd2,
    VM_EXT_ALT  = 2'd3
  } vcom_mode_e;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_MAINT  = 2'd1,
    LK_UPDATE = 2'd2,
    LK_CLEAR  = 2'd3
  } link_kind_e;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_CLR_UP = 3'd1,
    PS_PIN_UP = 3'd2,
    PS_ON     = 3'd3,
    PS_CLR_DN = 3'd4,
    PS_PIN_DN = 3'd5
  } pwr_state_e;

  // Header byte: bit2 clear, bit1 polarity, bit0 update; zero means maintain.
  function automatic logic [7:0] cmd_header(input link_kind_e kind, input logic pol);
    cmd_header = {5'b0, (kind == LK_CLEAR), pol, (kind == LK_UPDATE)};
  endfunction

endpackage

// File: rtl/vcom_timebase.sv
module vcom_timebase
  import vcom_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 200_000_000,
  parameter int HIGH_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic serial_en,
  input  logic pulse_en,
  output logic tick_maint,
  output logic pol,
  output logic extcom
);

  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
  localparam logic [CW-1:0] HIGH = CW'(HIGH_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pol_q, pol_d;
  logic          ext_q, ext_d;
  logic          active, tick_c;

  always_comb begin
    active = run && (serial_en || pulse_en);
    tick_c = active && (cnt_q == LAST);
    if (!active)      cnt_d = '0;
    else if (tick_c)  cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    pol_d = (tick_c && serial_en) ? ~pol_q : pol_q;
    ext_d = run && pulse_en && (cnt_q < HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pol_q <= pol_d;
      ext_q <= ext_d;
    end
  end

  assign tick_maint = tick_c && serial_en;
  assign pol        = pol_q;
  assign extcom     = ext_q;

  // R3: polarity only moves on a serial tick
  p_pol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_maint |=> $stable(pol_q));

  // R4: pulse output drops once generation stops
  p_ext_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ext_q);

endmodule

// File: rtl/vcom_link_arb.sv
module vcom_link_arb
  import vcom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_kick,
  input  logic       tick_maint,
  input  logic       run,
  input  logic       upd_req,
  input  logic       upd_allow,
  input  logic       link_done,
  input  logic       pol,
  output logic       clr_done,
  output logic       link_start,
  output logic [1:0] link_kind,
  output logic [7:0] link_hdr
);

  logic       busy_q, busy_d;
  logic       cpend_q, cpend_d;
  logic       mpend_q, mpend_d;
  logic       start_q, start_d;
  link_kind_e kind_q, kind_d;
  logic [7:0] hdr_q, hdr_d;
  logic       g_clr, g_mnt, g_upd, g_any;

  always_comb begin
    g_clr = !busy_q && cpend_q;
    g_mnt = !busy_q && !cpend_q && mpend_q;
    g_upd = !busy_q && !cpend_q && !mpend_q && upd_req && upd_allow;
    g_any = g_clr || g_mnt || g_upd;

    cpend_d = cpend_q;
    if (g_clr)    cpend_d = 1'b0;
    if (clr_kick) cpend_d = 1'b1;

    mpend_d = mpend_q;
    if (g_mnt)      mpend_d = 1'b0;
    if (tick_maint) mpend_d = 1'b1;
    if (!run)       mpend_d = 1'b0;

    busy_d = busy_q;
    if (link_done) busy_d = 1'b0;
    if (g_any)     busy_d = 1'b1;

    start_d = g_any;
    kind_d  = kind_q;
    if (g_clr)      kind_d = LK_CLEAR;
    else if (g_mnt) kind_d = LK_MAINT;
    else if (g_upd) kind_d = LK_UPDATE;
    hdr_d = g_any ? cmd_header(kind_d, pol) : hdr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cpend_q <= 1'b0;
      mpend_q <= 1'b0;
      start_q <= 1'b0;
      kind_q  <= LK_IDLE;
      hdr_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      cpend_q <= cpend_d;
      mpend_q <= mpend_d;
      start_q <= start_d;
      kind_q  <= kind_d;
      hdr_q   <= hdr_d;
    end
  end

  assign clr_done   = busy_q && link_done && (kind_q == LK_CLEAR);
  assign link_start = start_q;
  assign link_kind  = kind_q;
  assign link_hdr   = hdr_q;

  // R6: no new grant while a command is outstanding
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !link_done) |=> !start_q);

  // R9: updates only leave while the panel is on
  p_upd_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && kind_q == LK_UPDATE) |-> $past(upd_allow));

  // R10: a pending clear wins a free link
  p_clr_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cpend_q) |=> (start_q && kind_q == LK_CLEAR));

endmodule

// File: rtl/vcom_power_seq.sv
module vcom_power_seq
  import vcom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic [1:0] mode_in,
  input  logic       clr_done,
  output logic       clr_kick,
  output logic       disp_en,
  output logic       run,
  output logic       serial_en,
  output logic       pulse_en,
  output logic       live
);

  pwr_state_e st_q, st_d;
  vcom_mode_e mode_q, mode_d;
  logic       disp_q, disp_d;
  logic       run_q, run_d;
  logic       kick_q, kick_d;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    disp_d = disp_q;
    run_d  = run_q;
    kick_d = 1'b0;
    case (st_q)
      PS_OFF: if (en_req) begin
        st_d   = PS_CLR_UP;
        kick_d = 1'b1;
        mode_d = vcom_mode_e'(mode_in);
      end
      PS_CLR_UP: if (clr_done) begin
        st_d   = PS_PIN_UP;
        disp_d = 1'b1;
      end
      PS_PIN_UP: begin
        st_d  = PS_ON;
        run_d = 1'b1;
      end
      PS_ON: if (!en_req) begin
        st_d   = PS_CLR_DN;
        kick_d = 1'b1;
      end
      PS_CLR_DN: if (clr_done) begin
        st_d   = PS_PIN_DN;
        disp_d = 1'b0;
      end
      PS_PIN_DN: begin
        st_d  = PS_OFF;
        run_d = 1'b0;
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_OFF;
      mode_q <= VM_EXTERNAL;
      disp_q <= 1'b0;
      run_q  <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      disp_q <= disp_d;
      run_q  <= run_d;
      kick_q <= kick_d;
    end
  end

  assign clr_kick  = kick_q;
  assign disp_en   = disp_q;
  assign run       = run_q;
  assign serial_en = (mode_q == VM_SERIAL);
  assign pulse_en  = (mode_q == VM_PULSE);
  assign live      = (st_q == PS_ON);

  // R7: the pin is already high when generation starts
  p_pin_before_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> disp_q);

  // R8: the pin is already low when generation stops
  p_pin_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !disp_q);

  // R2: captured mode holds outside the off state
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PS_OFF) |=> $stable(mode_q));

endmodule

// File: rtl/vcom_seq.sv
module vcom_seq
  import vcom_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 200_000_000,
  parameter int HIGH_CYCLES = 20_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic [1:0] mode_sel,
  input  logic       upd_req,
  input  logic       link_done,
  output logic       link_start,
  output logic [1:0] link_kind,
  output logic [7:0] link_hdr,
  output logic       disp_en,
  output logic       extcom
);

  logic clr_kick, clr_done, run, serial_en, pulse_en, live;
  logic tick_maint, pol;

  vcom_power_seq u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req),
    .mode_in   (mode_sel),
    .clr_done  (clr_done),
    .clr_kick  (clr_kick),
    .disp_en   (disp_en),
    .run       (run),
    .serial_en (serial_en),
    .pulse_en  (pulse_en),
    .live      (live)
  );

  vcom_timebase #(
    .TICK_CYCLES (TICK_CYCLES),
    .HIGH_CYCLES (HIGH_CYCLES)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .serial_en  (serial_en),
    .pulse_en   (pulse_en),
    .tick_maint (tick_maint),
    .pol        (pol),
    .extcom     (extcom)
  );

  vcom_link_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_kick   (clr_kick),
    .tick_maint (tick_maint),
    .run        (run),
    .upd_req    (upd_req),
    .upd_allow  (live),
    .link_done  (link_done),
    .pol        (pol),
    .clr_done   (clr_done),
    .link_start (link_start),
    .link_kind  (link_kind),
    .link_hdr   (link_hdr)
  );

endmodule

// File: tb/test_vcom_seq.sv
`timescale 1ns/100ps
module test_vcom_seq;

  localparam int TICK = 40;
  localparam int HIGH = 6;

  logic clk, rst_n, en_req, upd_req, link_done;
  logic [1:0] mode_sel;
  logic link_start, disp_en, extcom;
  logic [1:0] link_kind;
  logic [7:0] link_hdr;

  vcom_seq #(.TICK_CYCLES(TICK), .HIGH_CYCLES(HIGH)) i_vcom_seq (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .mode_sel(mode_sel),
    .upd_req(upd_req), .link_done(link_done), .link_start(link_start),
    .link_kind(link_kind), .link_hdr(link_hdr), .disp_en(disp_en), .extcom(extcom)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  int m_st, m_cnt, m_kind;
  bit m_disp, m_run, m_kick, m_ext, m_vcom, m_busy, m_cp, m_mp, m_start;
  bit [1:0] m_mode;
  logic [7:0] m_hdr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_kind = 0; m_disp = 0; m_run = 0; m_kick = 0; m_ext = 0;
      m_vcom = 0; m_busy = 0; m_cp = 0; m_mp = 0; m_start = 0; m_mode = 2'd1; m_hdr = 8'h00;
    end else begin : mstep
      bit ser, pul, act, tick, gc, gm, gu, cdone;
      ser = (m_mode == 2'd0);
      pul = (m_mode == 2'd2);
      act = m_run && (ser || pul);
      tick = act && (m_cnt == TICK - 1);
      gc = !m_busy && m_cp;
      gm = !m_busy && !m_cp && m_mp;
      gu = !m_busy && !m_cp && !m_mp && upd_req && (m_st == 3);
      cdone = m_busy && link_done && (m_kind == 3);
      m_start = gc || gm || gu;
      if (m_start) begin
        m_kind = gc ? 3 : (gm ? 1 : 2);
        m_hdr = {5'b0, gc, m_vcom, gu};
      end
      m_ext = m_run && pul && (m_cnt < HIGH);
      m_cnt = act ? (tick ? 0 : m_cnt + 1) : 0;
      if (tick && ser) m_vcom = !m_vcom;
      if (m_start) m_busy = 1; else if (link_done) m_busy = 0;
      if (m_kick) m_cp = 1; else if (gc) m_cp = 0;
      if (!m_run) m_mp = 0; else if (tick && ser) m_mp = 1; else if (gm) m_mp = 0;
      m_kick = 0;
      case (m_st)
        0: if (en_req) begin m_st = 1; m_kick = 1; m_mode = mode_sel; end
        1: if (cdone) begin m_st = 2; m_disp = 1; end
        2: begin m_st = 3; m_run = 1; end
        3: if (!en_req) begin m_st = 4; m_kick = 1; end
        4: if (cdone) begin m_st = 5; m_disp = 0; end
        default: begin m_st = 0; m_run = 0; end
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      chk(disp_en == m_disp, "R7 R8 disp_en", int'(disp_en), int'(m_disp));
      chk(extcom == m_ext, "R4 R5 extcom", int'(extcom), int'(m_ext));
      chk(link_start == m_start, "R6 R10 link_start", int'(link_start), int'(m_start));
      if (m_start) begin
        chk(int'(link_kind) == m_kind, "R9 R10 link_kind", int'(link_kind), m_kind);
        chk(link_hdr == m_hdr, "R3 R9 link_hdr", int'(link_hdr), int'(m_hdr));
      end
    end
  end

  // serializer stand-in and event recorder
  int lat = 3, cd = 0, out_kind = 0, upd_done_cyc = -1;
  int n_maint = 0, n_upd = 0, n_ext_hi = 0;
  bit spur = 0, ext_prev = 0;
  int maint_hdr[$], maint_cyc[$], rise_cyc[$], fall_cyc[$];

  always @(negedge clk) begin
    link_done = spur;
    if (link_start) begin
      cd = lat;
      out_kind = int'(link_kind);
      if (link_kind == 2'd1) begin
        n_maint++; maint_hdr.push_back(int'(link_hdr)); maint_cyc.push_back(cyc);
      end
      if (link_kind == 2'd2) n_upd++;
    end else if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        link_done = 1'b1;
        if (out_kind == 2) upd_done_cyc = cyc;
      end
    end
    if (extcom) n_ext_hi++;
    if (extcom && !ext_prev) rise_cyc.push_back(cyc);
    if (!extcom && ext_prev) fall_cyc.push_back(cyc);
    ext_prev = extcom;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power(input bit on);
    en_req = on;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (disp_en == on) break;
    end
    wait_cycles(2);
  endtask

  task automatic do_update();
    upd_req = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (link_start && link_kind == 2'd2) break;
    end
    upd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; en_req = 0; upd_req = 0; mode_sel = 2'd0; link_done = 0;
    wait_cycles(4);
    rst_n = 1;
    wait_cycles(1);
    // R1: reset state
    chk(disp_en == 0, "R1 disp_en", int'(disp_en), 0);
    chk(extcom == 0, "R1 extcom", int'(extcom), 0);
    chk(link_start == 0, "R1 link_start", int'(link_start), 0);

    // serial mode, two undisturbed periods
    mode_sel = 2'd0;
    power(1);
    mode_sel = 2'd2; // R2: ignored while on
    base = n_ext_hi;
    wait_cycles(2 * TICK + 5);
    do_update();
    wait_cycles(10);
    chk(maint_hdr.size() >= 2, "R3 maintain count", maint_hdr.size(), 2);
    if (maint_hdr.size() >= 2) begin
      chk(maint_hdr[0] == 8'h02, "R1 R3 first maintain header", maint_hdr[0], 8'h02);
      chk(maint_hdr[1] == 8'h00, "R3 second maintain header", maint_hdr[1], 8'h00);
      chk(maint_cyc[1] - maint_cyc[0] == TICK, "R3 maintain spacing", maint_cyc[1] - maint_cyc[0], TICK);
    end

    // R10: maintain falling due during a long update
    while (!(m_run && m_cnt == TICK - 6)) @(negedge clk);
    lat = 15;
    do_update();
    wait_cycles(25);
    lat = 3;
    chk(maint_cyc[$] == upd_done_cyc + 2, "R10 deferred maintain start", maint_cyc[$], upd_done_cyc + 2);
    chk(n_ext_hi == base, "R2 extcom in serial after mode change", n_ext_hi - base, 0);
    power(0);

    // R9: updates while off are not granted
    base = n_upd;
    upd_req = 1'b1;
    wait_cycles(60);
    upd_req = 1'b0;
    chk(n_upd == base, "R9 update while off", n_upd - base, 0);

    // pulse mode
    mode_sel = 2'd2;
    rise_cyc.delete(); fall_cyc.delete();
    power(1);
    wait_cycles(3 * TICK);
    chk(rise_cyc.size() >= 2, "R4 pulse rises", rise_cyc.size(), 3);
    if (rise_cyc.size() >= 2 && fall_cyc.size() >= 1) begin
      chk(rise_cyc[1] - rise_cyc[0] == TICK, "R4 pulse period", rise_cyc[1] - rise_cyc[0], TICK);
      chk(fall_cyc[0] - rise_cyc[0] == HIGH, "R4 pulse high time", fall_cyc[0] - rise_cyc[0], HIGH);
    end
    // R11: stray done while idle
    spur = 1; wait_cycles(1); spur = 0;
    wait_cycles(2);
    base = n_upd;
    do_update();
    wait_cycles(8);
    chk(n_upd == base + 1, "R11 update after stray done", n_upd - base, 1);
    power(0);
    wait_cycles(3);
    chk(extcom == 0, "R4 extcom low after disable", int'(extcom), 0);

    // external encodings
    for (int m = 1; m <= 3; m += 2) begin
      mode_sel = 2'(m);
      base = n_maint;
      n_ext_hi = 0;
      power(1);
      wait_cycles(3 * TICK);
      do_update();
      wait_cycles(5);
      power(0);
      chk(n_maint == base, "R5 no maintain in external", n_maint - base, 0);
      chk(n_ext_hi == 0, "R5 extcom silent in external", n_ext_hi, 0);
    end

    wait_cycles(5);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule